// File: doc/BRIEF.md
# Quasi-Bidirectional Port Pin Controller

This block holds the output latch of an 8-bit general-purpose port and works out, for each pin, which of three pad drivers is switched on: a strong pull-down, a short strong pull-up boost, or a weak keeper pull-up. A pin whose latch bit is 1 serves as an input, because only the weak keeper holds it high, or in the open-drain variant nothing holds it at all. Software can write the latch as a full byte or one bit at a time. It can read back the latch for read-modify-write work, or read the synchronized pin levels.

A build-time parameter selects the variant. In the quasi-bidirectional form, every rise of a pin's driven value from 0 to 1 fires a strong pull-up boost of fixed length, and the weak keeper follows it. In the open-drain form, a 1 releases the pin completely. Any pin can be handed to a special function. Its driven value then comes from that function's output instead of the latch, and the other pins are not affected.

Top module: `qbp_port_ctrl`

## Requirements
- R1: After reset every latch bit reads 1 on `rd_latch`, `pd_en` and `spu_en` are all 0, and `wpu_en` is all 1 in the quasi variant and all 0 in the open-drain variant.
- R2: A latch bit written with 0 sets its `pd_en` bit from the cycle after the write, and the bit stays set until a 1 is written to that bit.
- R3: In the quasi variant, when a pin's driven value goes from 0 to 1, `spu_en` for that pin is 1 for exactly PULSE_CYC (default 2) cycles, starting in the cycle the new value is present. After that, `wpu_en` is 1.
- R4: Writing 1 to a latch bit that already holds 1 fires no boost on that pin.
- R5: In the open-drain variant, `spu_en` and `wpu_en` are never set, and a driven value of 1 leaves all three enables of that pin at 0.
- R6: A bit write (`wr_bit_sel` gives the bit index, 0 = LSB) changes only the selected bit. When a byte write and a bit write come in the same cycle, the byte is applied and then the bit write overrides its own position.
- R7: The pin levels never change the latch contents seen on `rd_latch`.
- R8: `rd_pin` returns `pin_in` delayed by two clock edges, and it reads 0 after reset.
- R9: While `sf_en[i]` is 1, pin i is driven from `sf_val[i]` instead of its latch bit, which still accepts writes. Other pins keep following their latches. A 0-to-1 change of `sf_val[i]` fires a boost like R3.
- R10: On every pin, at most one of `pd_en`, `spu_en` and `wpu_en` is 1 at any time.
- R11: If a pin's driven value returns to 0 during a boost, the boost ends at once, and only `pd_en` is set for that pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_byte_en | input | 1 | Write the whole latch |
| wr_byte_data | input | WIDTH | Byte to write |
| wr_bit_en | input | 1 | Write one latch bit |
| wr_bit_sel | input | $clog2(WIDTH) | Index of the bit to write |
| wr_bit_val | input | 1 | Value for the bit write |
| sf_en | input | WIDTH | Per-pin special-function select |
| sf_val | input | WIDTH | Per-pin special-function output value |
| pin_in | input | WIDTH | Sensed pin levels |
| rd_latch | output | WIDTH | Latch contents (read-modify-write path) |
| rd_pin | output | WIDTH | Synchronized pin levels |
| pd_en | output | WIDTH | Strong pull-down enable per pin |
| spu_en | output | WIDTH | Strong pull-up boost enable per pin |
| wpu_en | output | WIDTH | Weak keeper pull-up enable per pin |

## Verification
The hardest situation to reach is a boost cut short by a 0 (R11). A new write has to land in the first cycle of the boost, while the countdown is already loaded. The stimulus drives a bit write of 0 on the same falling edge at which it samples the first boost cycle, so the write lands on the following clock edge. A boost fired by a special-function value rather than by a latch write (R9) is reached by toggling `sf_val` while `sf_en` is held. Because that path is combinational, it is sampled just after the input changes.

// File: rtl/qbp_pkg.sv
package qbp_pkg;

  typedef enum logic [1:0] {
    DRV_NONE    = 2'd0,
    DRV_PULL_DN = 2'd1,
    DRV_BOOST   = 2'd2,
    DRV_KEEP    = 2'd3
  } drive_e;

  // Pad driver choice for one pin: low value wins, then variant, then boost.
  function automatic drive_e pick_drive(input logic eff, input logic boosting,
                                        input logic open_drain);
    if (!eff)       return DRV_PULL_DN;
    if (open_drain) return DRV_NONE;
    if (boosting)   return DRV_BOOST;
    return DRV_KEEP;
  endfunction

endpackage

// File: rtl/qbp_latch.sv
module qbp_latch #(
  parameter int WIDTH = 8,
  localparam int SELW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_en,
  input  logic [WIDTH-1:0] byte_data,
  input  logic             bit_en,
  input  logic [SELW-1:0]  bit_sel,
  input  logic             bit_val,
  output logic [WIDTH-1:0] latch_q
);

  // Byte first, then the single-bit write overrides its own position.
  function automatic logic [WIDTH-1:0] merge_write(
    input logic [WIDTH-1:0] cur, input logic b_en, input logic [WIDTH-1:0] b_data,
    input logic s_en, input logic [SELW-1:0] s_sel, input logic s_val);
    logic [WIDTH-1:0] r;
    r = b_en ? b_data : cur;
    if (s_en) r[s_sel] = s_val;
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '1;
    else        latch_q <= merge_write(latch_q, byte_en, byte_data, bit_en, bit_sel, bit_val);
  end

endmodule

// File: rtl/qbp_sync.sv
module qbp_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= {stage_q[STAGES-2:0], din};
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/qbp_pin_drive.sv
module qbp_pin_drive
  import qbp_pkg::*;
#(
  parameter int PULSE_CYC  = 2,
  parameter bit OPEN_DRAIN = 1'b0,
  localparam int CW = $clog2(PULSE_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic eff,
  output logic pd,
  output logic spu,
  output logic wpu,
  output logic rise_o
);

  localparam logic [CW-1:0] LOAD = CW'(PULSE_CYC - 1);

  logic          prev_q;
  logic [CW-1:0] cnt_q;
  logic          boosting;
  drive_e        drv;

  assign rise_o   = eff & ~prev_q;
  assign boosting = rise_o | (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      prev_q <= eff;
      if (!eff)            cnt_q <= '0;
      else if (rise_o)     cnt_q <= LOAD;
      else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign drv = pick_drive(eff, boosting, OPEN_DRAIN);
  assign pd  = (drv == DRV_PULL_DN);
  assign spu = (drv == DRV_BOOST);
  assign wpu = (drv == DRV_KEEP);

endmodule

// File: rtl/qbp_port_ctrl.sv
module qbp_port_ctrl #(
  parameter int WIDTH       = 8,
  parameter int PULSE_CYC   = 2,
  parameter bit OPEN_DRAIN  = 1'b0,
  parameter int SYNC_STAGES = 2,
  localparam int SELW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_byte_en,
  input  logic [WIDTH-1:0] wr_byte_data,
  input  logic             wr_bit_en,
  input  logic [SELW-1:0]  wr_bit_sel,
  input  logic             wr_bit_val,
  input  logic [WIDTH-1:0] sf_en,
  input  logic [WIDTH-1:0] sf_val,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] rd_latch,
  output logic [WIDTH-1:0] rd_pin,
  output logic [WIDTH-1:0] pd_en,
  output logic [WIDTH-1:0] spu_en,
  output logic [WIDTH-1:0] wpu_en
);

  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] eff_vec;   // value each pin is driven toward
  logic [WIDTH-1:0] rise_vec;  // per-pin 0->1 event, for the checker

  qbp_latch #(.WIDTH(WIDTH)) u_latch (
    .clk(clk), .rst_n(rst_n),
    .byte_en(wr_byte_en), .byte_data(wr_byte_data),
    .bit_en(wr_bit_en), .bit_sel(wr_bit_sel), .bit_val(wr_bit_val),
    .latch_q(latch_q)
  );

  qbp_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(rd_pin)
  );

  assign eff_vec  = (sf_en & sf_val) | (~sf_en & latch_q);
  assign rd_latch = latch_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    qbp_pin_drive #(.PULSE_CYC(PULSE_CYC), .OPEN_DRAIN(OPEN_DRAIN)) u_drv (
      .clk(clk), .rst_n(rst_n), .eff(eff_vec[i]),
      .pd(pd_en[i]), .spu(spu_en[i]), .wpu(wpu_en[i]), .rise_o(rise_vec[i])
    );
  end

endmodule

// File: rtl/qbp_port_chk.sv
module qbp_port_chk #(
  parameter int WIDTH      = 8,
  parameter bit OPEN_DRAIN = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_byte_en,
  input logic [WIDTH-1:0] wr_byte_data,
  input logic             wr_bit_en,
  input logic [WIDTH-1:0] sf_en,
  input logic [WIDTH-1:0] pin_in,
  input logic [WIDTH-1:0] rd_latch,
  input logic [WIDTH-1:0] rd_pin,
  input logic [WIDTH-1:0] pd_en,
  input logic [WIDTH-1:0] spu_en,
  input logic [WIDTH-1:0] wpu_en,
  input logic [WIDTH-1:0] rise_vec
);

  logic [1:0] up_cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            up_cyc <= '0;
    else if (up_cyc != 2'd3) up_cyc <= up_cyc + 2'd1;
  end

  AST_RESET_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> rd_latch == '1); // R1

  AST_PD_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_byte_en && !wr_bit_en) |=> (sf_en != '0) || (pd_en == ~$past(wr_byte_data))); // R2

  AST_BOOST_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (spu_en & ~$past(spu_en) & ~$past(pd_en)) == '0); // R3

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_byte_en && !wr_bit_en) |=> $stable(rd_latch)); // R7

  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cyc >= 2'd2) |-> rd_pin == $past(pin_in, 2)); // R8

  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    ((pd_en & spu_en) | (pd_en & wpu_en) | (spu_en & wpu_en)) == '0); // R10

  if (OPEN_DRAIN) begin : g_od
    AST_OD_NO_PULLUP: assert property (@(posedge clk) disable iff (!rst_n)
      (spu_en | wpu_en) == '0); // R5
  end else begin : g_qb
    AST_RISE_BOOSTS: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_vec & ~spu_en) == '0); // R3
  end

endmodule

bind qbp_port_ctrl qbp_port_chk #(.WIDTH(WIDTH), .OPEN_DRAIN(OPEN_DRAIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_byte_en(wr_byte_en), .wr_byte_data(wr_byte_data),
  .wr_bit_en(wr_bit_en), .sf_en(sf_en), .pin_in(pin_in), .rd_latch(rd_latch),
  .rd_pin(rd_pin), .pd_en(pd_en), .spu_en(spu_en), .wpu_en(wpu_en), .rise_vec(rise_vec)
);

// File: tb/sim_qbp_port_ctrl.sv
`timescale 1ns/1ps
module sim_qbp_port_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_byte_en = 1'b0;
  logic [7:0] wr_byte_data = '0;
  logic       wr_bit_en = 1'b0;
  logic [2:0] wr_bit_sel = '0;
  logic       wr_bit_val = 1'b0;
  logic [7:0] sf_en = '0, sf_val = '0, pin_in = '0;
  logic [7:0] rd_latch, rd_pin, pd_en, spu_en, wpu_en;
  logic [7:0] od_latch, od_pin, od_pd, od_spu, od_wpu;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  qbp_port_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_byte_en(wr_byte_en), .wr_byte_data(wr_byte_data),
    .wr_bit_en(wr_bit_en), .wr_bit_sel(wr_bit_sel), .wr_bit_val(wr_bit_val),
    .sf_en(sf_en), .sf_val(sf_val), .pin_in(pin_in), .rd_latch(rd_latch),
    .rd_pin(rd_pin), .pd_en(pd_en), .spu_en(spu_en), .wpu_en(wpu_en)
  );

  qbp_port_ctrl #(.OPEN_DRAIN(1'b1)) u_od (
    .clk(clk), .rst_n(rst_n), .wr_byte_en(wr_byte_en), .wr_byte_data(wr_byte_data),
    .wr_bit_en(wr_bit_en), .wr_bit_sel(wr_bit_sel), .wr_bit_val(wr_bit_val),
    .sf_en(sf_en), .sf_val(sf_val), .pin_in(pin_in), .rd_latch(od_latch),
    .rd_pin(od_pin), .pd_en(od_pd), .spu_en(od_spu), .wpu_en(od_wpu)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act,
                     input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic excl(input string req);
    chk(req, "one driver", (pd_en & spu_en) | (pd_en & wpu_en) | (spu_en & wpu_en), 8'h00);
  endtask

  task automatic wr_byte(input logic [7:0] d);
    @(negedge clk); wr_byte_en = 1'b1; wr_byte_data = d;
    @(negedge clk); wr_byte_en = 1'b0;
  endtask

  task automatic wr_bit(input logic [2:0] sel, input logic val);
    @(negedge clk); wr_bit_en = 1'b1; wr_bit_sel = sel; wr_bit_val = val;
    @(negedge clk); wr_bit_en = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "latch", rd_latch, 8'hFF);
    chk("R1", "pd", pd_en, 8'h00);
    chk("R1", "spu", spu_en, 8'h00);
    chk("R1", "wpu", wpu_en, 8'hFF);
    chk("R1", "od wpu", od_wpu, 8'h00);
    chk("R8", "pin reset", rd_pin, 8'h00);
  endtask

  task automatic t_pull_down();
    wr_byte(8'hA5);
    chk("R2", "pd", pd_en, 8'h5A);
    chk("R2", "wpu", wpu_en, 8'hA5);
    settle();
    chk("R2", "pd held", pd_en, 8'h5A);
    excl("R10");
  endtask

  task automatic t_boost();
    wr_byte(8'hFF);
    chk("R3", "boost c1", spu_en, 8'h5A);
    chk("R3", "keep c1", wpu_en, 8'hA5);
    excl("R10");
    @(negedge clk);
    chk("R3", "boost c2", spu_en, 8'h5A);
    @(negedge clk);
    chk("R3", "boost end", spu_en, 8'h00);
    chk("R3", "keeper", wpu_en, 8'hFF);
  endtask

  task automatic t_rewrite();
    wr_byte(8'hFF);
    chk("R4", "byte rewrite", spu_en, 8'h00);
    wr_bit(3'd3, 1'b1);
    chk("R4", "bit rewrite", spu_en, 8'h00);
  endtask

  task automatic t_bit_write();
    wr_bit(3'd2, 1'b0);
    chk("R6", "bit2 clear", rd_latch, 8'hFB);
    @(negedge clk);
    wr_byte_en = 1'b1; wr_byte_data = 8'h00;
    wr_bit_en = 1'b1; wr_bit_sel = 3'd7; wr_bit_val = 1'b1;
    @(negedge clk);
    wr_byte_en = 1'b0; wr_bit_en = 1'b0;
    chk("R6", "byte+bit", rd_latch, 8'h80);
    wr_byte(8'hFF);
    settle();
  endtask

  task automatic t_pins();
    @(negedge clk); pin_in = 8'h00;
    repeat (2) @(negedge clk);
    chk("R7", "latch vs pins", rd_latch, 8'hFF);
    pin_in = 8'h3C;
    @(negedge clk);
    chk("R8", "one edge", rd_pin, 8'h00);
    chk("R7", "latch vs 3C", rd_latch, 8'hFF);
    @(negedge clk);
    chk("R8", "two edges", rd_pin, 8'h3C);
  endtask

  task automatic t_special();
    @(negedge clk); sf_en = 8'h01; sf_val = 8'h00;
    #1;
    chk("R9", "sf pd", pd_en, 8'h01);
    chk("R9", "others keep", wpu_en, 8'hFE);
    chk("R9", "latch kept", rd_latch, 8'hFF);
    @(negedge clk); sf_val = 8'h01;
    #1;
    chk("R9", "sf boost c1", spu_en, 8'h01);
    @(negedge clk);
    chk("R9", "sf boost c2", spu_en, 8'h01);
    @(negedge clk);
    chk("R9", "sf keeper", wpu_en, 8'hFF);
    wr_bit(3'd0, 1'b0);
    chk("R9", "latch write hidden", pd_en, 8'h00);
    chk("R9", "latch took write", rd_latch, 8'hFE);
    sf_en = 8'h00;
    #1;
    chk("R9", "latch back", pd_en, 8'h01);
    wr_byte(8'hFF);
    settle();
  endtask

  task automatic t_cancel();
    wr_byte(8'h00);
    chk("R2", "all low", pd_en, 8'hFF);
    chk("R5", "od pd", od_pd, 8'hFF);
    wr_bit(3'd0, 1'b1);
    chk("R11", "boost start", spu_en, 8'h01);
    wr_bit_en = 1'b1; wr_bit_sel = 3'd0; wr_bit_val = 1'b0;
    @(negedge clk); wr_bit_en = 1'b0;
    chk("R11", "cut spu", spu_en, 8'h00);
    chk("R11", "cut pd", pd_en, 8'hFF);
    chk("R11", "cut wpu", wpu_en, 8'h00);
    wr_byte(8'hFF);
    chk("R5", "od release pd", od_pd, 8'h00);
    chk("R5", "od release spu", od_spu, 8'h00);
    chk("R5", "od release wpu", od_wpu, 8'h00);
    excl("R10");
    settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_pull_down();
    t_boost();
    t_rewrite();
    t_bit_write();
    t_pins();
    t_special();
    t_cancel();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule